// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

An 8-bit execution unit for an accumulator-style microcontroller datapath. It keeps one working register (W) and one status register. In each cycle it can take an operation code, one operand byte and a destination-select bit. The operand byte is either a value read from a file register or an immediate literal. The unit computes the result and sends it to one of two places. It either loads the result into W on the next rising clock edge, or it drives the result back toward the file register through a combinational write strobe in the same cycle.

The status register carries five flags: carry, digit carry, zero, signed overflow and negative. Each class of operation updates its own subset of these flags. Arithmetic updates all five. Bitwise logic, complement and the file move update only zero and negative. Rotates through carry update carry, zero and negative. Pure data moves and the nibble swap leave the flags alone.

The file register array, banking, instruction fetch and decode, and branch or skip sequencing all sit outside this block. A literal can reach data memory only by loading it into W and then storing W.

Top module: `acc_alu_core`

## Requirements
- R1: `op_code` encodes the operation as follows. 0 load literal into W, 1 store W to file, 2 move file, 3 add, 4 add with carry, 5 file minus W, 6 file minus W with borrow, 7 W minus file with borrow, 8 AND, 9 OR, 10 XOR, 11 complement, 12 increment, 13 decrement, 14 negate, 15 rotate left through carry, 16 rotate right through carry, 17 nibble swap, 18 add literal, 19 AND literal, 20 OR literal, 21 XOR literal. For ops 3 to 10, W is the other operand.
- R2: With `op_dest`=0 the result is loaded into W on the next rising edge. With `op_dest`=1, `f_wr_en` is high and `f_wr_data` carries the result in the same cycle, and W is unchanged. Ops 0 and 18 to 21 always write W. Op 1 always writes the file with the value of W.
- R3: `status_q` holds C in bit 0, DC in bit 1, Z in bit 2, OV in bit 3 and N in bit 4. Bits 7 to 5 always read 0.
- R4: Addition (ops 3, 4, 18) sets C to the carry out of bit 7 and DC to the carry out of bit 3 into bit 4. OV is set on two's complement overflow, Z when the 8-bit result is zero, and N equal to bit 7 of the result. Add with carry adds C as an extra 1. For example, 38h+2Fh gives 67h with C=0, DC=1, Z=0, and 9Ch+64h gives 00h with C=1, DC=1, Z=1.
- R5: Subtraction (ops 5 to 7) updates all five flags. C=1 means no borrow out of bit 7, and DC=1 means no borrow out of bit 3. The borrow variants take away one extra when C=0.
- R6: Increment, decrement and negate (0 minus file) update all five flags by the same rules as addition of +1, addition of FFh, and 0 minus file.
- R7: AND, OR, XOR (file and literal forms), complement and move-file update only Z and N. C, DC and OV keep their values.
- R8: Rotate left gives {f[6:0],C} and loads C from f[7]. Rotate right gives {C,f[7:1]} and loads C from f[0]. Both update only C, Z and N.
- R9: Load literal, store W and nibble swap change no flag. Swap exchanges bits 7:4 with bits 3:0.
- R10: When `op_valid` is low, or when the code is 22 to 31, W and the status register keep their values and `f_wr_en` stays low.
- R11: An active-low reset clears W and the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Operation code (R1) |
| op_dest | input | 1 | 0 = result to W, 1 = result to file register |
| op_data | input | 8 | File register value or literal |
| w_q | output | 8 | Working register |
| status_q | output | 8 | Status register (R3) |
| f_wr_en | output | 1 | File register write strobe |
| f_wr_data | output | 8 | File register write data |

## Verification
The file write strobe and its data are combinational, so they are due in the same cycle as the operation. W and the status flags change on the first rising edge after the operation is presented. The bench drives each operation on a falling edge and checks the combinational write outputs 1 ns later. It checks W and status at the next falling edge, just before it drives the following operation. Every opcode is swept across all 256 operand values with changing W and carry. A reference model built from integer arithmetic predicts each flag.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int FLAG_N = 5;
  localparam int F_C  = 0;
  localparam int F_DC = 1;
  localparam int F_Z  = 2;
  localparam int F_OV = 3;
  localparam int F_N  = 4;

  localparam logic [FLAG_N-1:0] UPD_NONE = 5'b00000;
  localparam logic [FLAG_N-1:0] UPD_ALL  = 5'b11111;
  localparam logic [FLAG_N-1:0] UPD_ZN   = 5'b10100;
  localparam logic [FLAG_N-1:0] UPD_CZN  = 5'b10101;

  typedef enum logic [4:0] {
    OP_LDW   = 5'd0,
    OP_STW   = 5'd1,
    OP_PASS  = 5'd2,
    OP_ADD   = 5'd3,
    OP_ADDC  = 5'd4,
    OP_SUBFW = 5'd5,
    OP_SUBFWB= 5'd6,
    OP_RSUBB = 5'd7,
    OP_AND   = 5'd8,
    OP_OR    = 5'd9,
    OP_XOR   = 5'd10,
    OP_INV   = 5'd11,
    OP_INC   = 5'd12,
    OP_DEC   = 5'd13,
    OP_NEG   = 5'd14,
    OP_ROL   = 5'd15,
    OP_ROR   = 5'd16,
    OP_SWAP  = 5'd17,
    OP_ADDK  = 5'd18,
    OP_ANDK  = 5'd19,
    OP_ORK   = 5'd20,
    OP_XORK  = 5'd21
  } op_e;

  localparam int OP_COUNT = 22;

  typedef enum logic [1:0] {ASEL_W, ASEL_OPD, ASEL_ZERO} asel_e;
  typedef enum logic [2:0] {BSEL_OPD, BSEL_NOPD, BSEL_NW, BSEL_ZERO, BSEL_ONES} bsel_e;
  typedef enum logic [1:0] {CSEL_0, CSEL_1, CSEL_C} csel_e;
  typedef enum logic [3:0] {
    RSEL_SUM, RSEL_AND, RSEL_OR, RSEL_XOR, RSEL_INV,
    RSEL_ROL, RSEL_ROR, RSEL_SWAP, RSEL_OPD, RSEL_W
  } rsel_e;

  typedef struct packed {
    logic              legal;
    logic              lit;
    logic              to_file;
    asel_e             asel;
    bsel_e             bsel;
    csel_e             csel;
    rsel_e             rsel;
    logic              rot_c;
    logic [FLAG_N-1:0] upd;
  } ctl_t;

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
  import acc_alu_pkg::*;
(
  input  logic [4:0] op_code,
  output ctl_t       ctl
);

  always_comb begin
    ctl         = '0;
    ctl.asel    = ASEL_W;
    ctl.bsel    = BSEL_OPD;
    ctl.csel    = CSEL_0;
    ctl.rsel    = RSEL_SUM;
    ctl.upd     = UPD_NONE;
    ctl.legal   = (int'(op_code) < OP_COUNT);
    case (op_code)
      OP_LDW: begin
        ctl.lit  = 1'b1;
        ctl.rsel = RSEL_OPD;
      end
      OP_STW: begin
        ctl.to_file = 1'b1;
        ctl.rsel    = RSEL_W;
      end
      OP_PASS: begin
        ctl.rsel = RSEL_OPD;
        ctl.upd  = UPD_ZN;
      end
      OP_ADD: begin
        ctl.upd = UPD_ALL;
      end
      OP_ADDC: begin
        ctl.csel = CSEL_C;
        ctl.upd  = UPD_ALL;
      end
      OP_SUBFW: begin
        ctl.asel = ASEL_OPD;
        ctl.bsel = BSEL_NW;
        ctl.csel = CSEL_1;
        ctl.upd  = UPD_ALL;
      end
      OP_SUBFWB: begin
        ctl.asel = ASEL_OPD;
        ctl.bsel = BSEL_NW;
        ctl.csel = CSEL_C;
        ctl.upd  = UPD_ALL;
      end
      OP_RSUBB: begin
        ctl.bsel = BSEL_NOPD;
        ctl.csel = CSEL_C;
        ctl.upd  = UPD_ALL;
      end
      OP_AND: begin
        ctl.rsel = RSEL_AND;
        ctl.upd  = UPD_ZN;
      end
      OP_OR: begin
        ctl.rsel = RSEL_OR;
        ctl.upd  = UPD_ZN;
      end
      OP_XOR: begin
        ctl.rsel = RSEL_XOR;
        ctl.upd  = UPD_ZN;
      end
      OP_INV: begin
        ctl.rsel = RSEL_INV;
        ctl.upd  = UPD_ZN;
      end
      OP_INC: begin
        ctl.asel = ASEL_OPD;
        ctl.bsel = BSEL_ZERO;
        ctl.csel = CSEL_1;
        ctl.upd  = UPD_ALL;
      end
      OP_DEC: begin
        ctl.asel = ASEL_OPD;
        ctl.bsel = BSEL_ONES;
        ctl.upd  = UPD_ALL;
      end
      OP_NEG: begin
        ctl.asel = ASEL_ZERO;
        ctl.bsel = BSEL_NOPD;
        ctl.csel = CSEL_1;
        ctl.upd  = UPD_ALL;
      end
      OP_ROL: begin
        ctl.rsel  = RSEL_ROL;
        ctl.rot_c = 1'b1;
        ctl.upd   = UPD_CZN;
      end
      OP_ROR: begin
        ctl.rsel  = RSEL_ROR;
        ctl.rot_c = 1'b1;
        ctl.upd   = UPD_CZN;
      end
      OP_SWAP: begin
        ctl.rsel = RSEL_SWAP;
      end
      OP_ADDK: begin
        ctl.lit = 1'b1;
        ctl.upd = UPD_ALL;
      end
      OP_ANDK: begin
        ctl.lit  = 1'b1;
        ctl.rsel = RSEL_AND;
        ctl.upd  = UPD_ZN;
      end
      OP_ORK: begin
        ctl.lit  = 1'b1;
        ctl.rsel = RSEL_OR;
        ctl.upd  = UPD_ZN;
      end
      OP_XORK: begin
        ctl.lit  = 1'b1;
        ctl.rsel = RSEL_XOR;
        ctl.upd  = UPD_ZN;
      end
      default: begin
        ctl.legal = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             c_out,
  output logic             c_mid,
  output logic             ovf
);

  localparam int MID = WIDTH / 2;

  logic [WIDTH:0] cy;

  assign cy[0] = cin;

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
    assign sum[gi]  = a[gi] ^ b[gi] ^ cy[gi];
    assign cy[gi+1] = (a[gi] & b[gi]) | (cy[gi] & (a[gi] ^ b[gi]));
  end

  assign c_out = cy[WIDTH];
  assign c_mid = cy[MID];
  assign ovf   = cy[WIDTH] ^ cy[WIDTH-1];

endmodule

// File: rtl/acc_alu_result.sv
module acc_alu_result
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  rsel_e            rsel,
  input  logic [WIDTH-1:0] sum,
  input  logic [WIDTH-1:0] wreg,
  input  logic [WIDTH-1:0] opd,
  input  logic             c_in,
  output logic [WIDTH-1:0] res,
  output logic             rot_c
);

  localparam int MID = WIDTH / 2;

  always_comb begin
    res   = sum;
    rot_c = 1'b0;
    case (rsel)
      RSEL_SUM:  res = sum;
      RSEL_AND:  res = wreg & opd;
      RSEL_OR:   res = wreg | opd;
      RSEL_XOR:  res = wreg ^ opd;
      RSEL_INV:  res = ~opd;
      RSEL_ROL: begin
        res   = {opd[WIDTH-2:0], c_in};
        rot_c = opd[WIDTH-1];
      end
      RSEL_ROR: begin
        res   = {c_in, opd[WIDTH-1:1]};
        rot_c = opd[0];
      end
      RSEL_SWAP: res = {opd[MID-1:0], opd[WIDTH-1:MID]};
      RSEL_OPD:  res = opd;
      RSEL_W:    res = wreg;
      default:   res = sum;
    endcase
  end

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [4:0]        op_code,
  input  logic              op_dest,
  input  logic [DATA_W-1:0] op_data,
  output logic [DATA_W-1:0] w_q,
  output logic [7:0]        status_q,
  output logic              f_wr_en,
  output logic [DATA_W-1:0] f_wr_data
);

  localparam int STAT_W = 8;
  localparam int PAD_W  = STAT_W - FLAG_N;

  ctl_t              ctl;
  logic [DATA_W-1:0] add_a;
  logic [DATA_W-1:0] add_b;
  logic              add_ci;
  logic [DATA_W-1:0] add_s;
  logic              add_co;
  logic              add_hc;
  logic              add_ov;
  logic [DATA_W-1:0] result;
  logic              rot_c;
  logic [FLAG_N-1:0] flg_q;
  logic [FLAG_N-1:0] flg_new;
  logic [FLAG_N-1:0] flg_d;
  logic [DATA_W-1:0] w_d;
  logic              go;
  logic              to_w;
  logic              w_en;
  logic              st_en;

  acc_alu_decode u_dec (
    .op_code (op_code),
    .ctl     (ctl)
  );

  always_comb begin
    case (ctl.asel)
      ASEL_W:    add_a = w_q;
      ASEL_OPD:  add_a = op_data;
      default:   add_a = '0;
    endcase
    case (ctl.bsel)
      BSEL_OPD:  add_b = op_data;
      BSEL_NOPD: add_b = ~op_data;
      BSEL_NW:   add_b = ~w_q;
      BSEL_ONES: add_b = '1;
      default:   add_b = '0;
    endcase
    case (ctl.csel)
      CSEL_1:  add_ci = 1'b1;
      CSEL_C:  add_ci = flg_q[F_C];
      default: add_ci = 1'b0;
    endcase
  end

  acc_alu_adder #(.WIDTH(DATA_W)) u_add (
    .a     (add_a),
    .b     (add_b),
    .cin   (add_ci),
    .sum   (add_s),
    .c_out (add_co),
    .c_mid (add_hc),
    .ovf   (add_ov)
  );

  acc_alu_result #(.WIDTH(DATA_W)) u_res (
    .rsel  (ctl.rsel),
    .sum   (add_s),
    .wreg  (w_q),
    .opd   (op_data),
    .c_in  (flg_q[F_C]),
    .res   (result),
    .rot_c (rot_c)
  );

  // steering and flag merge
  always_comb begin
    go    = op_valid & ctl.legal;
    to_w  = ctl.lit | (~ctl.to_file & ~op_dest);
    w_en  = go & to_w;
    st_en = go;
    w_d   = result;

    flg_new       = '0;
    flg_new[F_C]  = ctl.rot_c ? rot_c : add_co;
    flg_new[F_DC] = add_hc;
    flg_new[F_Z]  = (result == '0);
    flg_new[F_OV] = add_ov;
    flg_new[F_N]  = result[DATA_W-1];

    flg_d = (ctl.upd & flg_new) | (~ctl.upd & flg_q);
  end

  assign f_wr_en   = go & ~to_w;
  assign f_wr_data = result;
  assign status_q  = {{PAD_W{1'b0}}, flg_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q   <= '0;
      flg_q <= '0;
    end else begin
      if (w_en) begin
        w_q <= w_d;
      end
      if (st_en) begin
        flg_q <= flg_d;
      end
    end
  end

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [4:0]        op_code,
  input logic              op_dest,
  input logic [DATA_W-1:0] op_data,
  input logic [DATA_W-1:0] w_q,
  input logic [7:0]        status_q,
  input logic              f_wr_en,
  input logic [DATA_W-1:0] f_wr_data
);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(w_q) && $stable(status_q)));

  // R10
  idle_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !f_wr_en);

  // R2
  file_dest_keeps_w_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f_wr_en |=> $stable(w_q));

  // R2
  add_to_file_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_ADD && op_dest) |-> f_wr_en);

  // R9
  load_literal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_LDW) |=> (w_q == $past(op_data) && $stable(status_q)));

  // R2
  store_w_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_STW) |-> (f_wr_en && f_wr_data == w_q));

  // R7
  logic_keeps_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_AND || op_code == OP_OR || op_code == OP_XOR))
      |=> (status_q[F_C] == $past(status_q[F_C]) &&
           status_q[F_DC] == $past(status_q[F_DC]) &&
           status_q[F_OV] == $past(status_q[F_OV])));

  // R3
  status_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[7:5] == 3'b000);

endmodule

bind acc_alu_core acc_alu_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .op_dest   (op_dest),
  .op_data   (op_data),
  .w_q       (w_q),
  .status_q  (status_q),
  .f_wr_en   (f_wr_en),
  .f_wr_data (f_wr_data)
);

// File: tb/acc_alu_core_tb_top.sv
`timescale 1ns/1ps
module acc_alu_core_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid;
  logic [4:0] op_code;
  logic       op_dest;
  logic [7:0] op_data;
  logic [7:0] w_q;
  logic [7:0] status_q;
  logic       f_wr_en;
  logic [7:0] f_wr_data;

  int         n_vec = 0;
  int         n_bad = 0;
  logic [7:0] m_w   = 8'h00;
  logic [7:0] m_st  = 8'h00;
  string      last_tag = "R11";
  logic [7:0] lf = 8'h5A;

  always #4 clk = ~clk;

  acc_alu_core dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .op_dest   (op_dest),
    .op_data   (op_data),
    .w_q       (w_q),
    .status_q  (status_q),
    .f_wr_en   (f_wr_en),
    .f_wr_data (f_wr_data)
  );

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  function automatic int sx(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic string tag_of(input int op);
    if (op >= 22) return "R10";
    case (op)
      3, 4, 18:               return "R4";
      5, 6, 7:                return "R5";
      12, 13, 14:             return "R6";
      2, 8, 9, 10, 11, 19, 20, 21: return "R7";
      15, 16:                 return "R8";
      default:                return "R9";
    endcase
  endfunction

  // reference model: R1 opcode values, R3 status bit positions
  task automatic model(input int op, input bit d, input logic [7:0] fb,
                       output logic [7:0] res, output bit tow,
                       output bit legal, output logic [7:0] nst);
    int w  = int'(m_w);
    int f  = int'(fb);
    int c  = int'(m_st[0]);
    int bw = 1 - c;
    int s  = 0;
    int sr = 0;
    bit fc = 0;
    bit fdc = 0;
    logic [4:0] mask = 5'b00000;
    legal = (op < 22);
    tow   = (op == 0) || (op >= 18) || ((op != 1) && !d);
    res   = fb;
    case (op)
      0:  res = fb;
      1:  res = m_w;
      2:  begin res = fb; mask = 5'b10100; end
      3, 18: begin s = w + f; fc = s > 255; fdc = ((w & 15) + (f & 15)) > 15;
                   sr = sx(w) + sx(f); mask = 5'b11111; end
      4:  begin s = w + f + c; fc = s > 255; fdc = ((w & 15) + (f & 15) + c) > 15;
                sr = sx(w) + sx(f) + c; mask = 5'b11111; end
      5:  begin s = f - w; fc = s >= 0; fdc = ((f & 15) - (w & 15)) >= 0;
                sr = sx(f) - sx(w); mask = 5'b11111; end
      6:  begin s = f - w - bw; fc = s >= 0; fdc = ((f & 15) - (w & 15) - bw) >= 0;
                sr = sx(f) - sx(w) - bw; mask = 5'b11111; end
      7:  begin s = w - f - bw; fc = s >= 0; fdc = ((w & 15) - (f & 15) - bw) >= 0;
                sr = sx(w) - sx(f) - bw; mask = 5'b11111; end
      8, 19:  begin res = m_w & fb; mask = 5'b10100; end
      9, 20:  begin res = m_w | fb; mask = 5'b10100; end
      10, 21: begin res = m_w ^ fb; mask = 5'b10100; end
      11: begin res = ~fb; mask = 5'b10100; end
      12: begin s = f + 1; fc = f == 255; fdc = (f & 15) == 15;
                sr = sx(f) + 1; mask = 5'b11111; end
      13: begin s = f - 1; fc = f >= 1; fdc = (f & 15) >= 1;
                sr = sx(f) - 1; mask = 5'b11111; end
      14: begin s = -f; fc = f == 0; fdc = (f & 15) == 0;
                sr = -sx(f); mask = 5'b11111; end
      15: begin res = {fb[6:0], m_st[0]}; fc = fb[7]; mask = 5'b10101; end
      16: begin res = {m_st[0], fb[7:1]}; fc = fb[0]; mask = 5'b10101; end
      17: res = {fb[3:0], fb[7:4]};
      default: res = fb;
    endcase
    if (op inside {3, 4, 5, 6, 7, 12, 13, 14, 18}) res = 8'(s);
    nst = m_st;
    if (mask[0]) nst[0] = fc;
    if (mask[1]) nst[1] = fdc;
    if (mask[2]) nst[2] = (res == 8'h00);
    if (mask[3]) nst[3] = (sr < -128) || (sr > 127);
    if (mask[4]) nst[4] = res[7];
  endtask

  // one operation per cycle; previous op's registered results checked first
  task automatic step(input int op, input bit d, input logic [7:0] fb, input bit v);
    logic [7:0] res;
    logic [7:0] nst;
    bit tow;
    bit legal;
    bit exp_en;
    string tg;
    @(negedge clk);
    chk(last_tag, "w_q", w_q, m_w);
    chk(last_tag, "status_q", status_q, m_st);
    op_valid = v;
    op_code  = 5'(op);
    op_dest  = d;
    op_data  = fb;
    #1;
    model(op, d, fb, res, tow, legal, nst);
    tg = v ? tag_of(op) : "R10";
    if (v && legal && !tow && (op inside {3, 5, 11})) tg = "R2";
    exp_en = v && legal && !tow;
    chk(tg, "f_wr_en", {7'd0, f_wr_en}, {7'd0, exp_en});
    if (exp_en) chk(tg, "f_wr_data", f_wr_data, res);
    if (v && legal) begin
      if (tow) m_w = res;
      m_st = nst;
    end
    last_tag = tg;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n    = 1'b0;
    op_valid = 1'b0;
    op_code  = 5'd0;
    op_dest  = 1'b0;
    op_data  = 8'h00;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "w_q", w_q, 8'h00);
    chk("R11", "status_q", status_q, 8'h00);
    rst_n = 1'b1;

    // R4 worked examples, then R2 destination to file
    step(0, 0, 8'h38, 1);
    step(18, 0, 8'h2F, 1);
    step(0, 0, 8'h9C, 1);
    step(18, 0, 8'h64, 1);
    step(0, 0, 8'hFF, 1);
    step(3, 1, 8'h01, 1);
    step(1, 0, 8'h00, 1);

    // sweep: every opcode over every operand, with fresh W before each
    for (int op = 0; op < 32; op++) begin
      for (int f = 0; f < 256; f++) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        step(0, 0, lf, 1);
        step(op, f[0] ^ lf[1], 8'(f), 1);
      end
    end

    // R10 idle cycles carry arbitrary codes
    for (int k = 0; k < 40; k++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      step(k % 22, lf[0], lf, 0);
    end
    step(0, 0, 8'h00, 0);
    finish_run();
  end

endmodule